// File: doc/BRIEF.md
# Prioritised Interrupt Router with Claim/Complete Service

This block takes a parameterised set of external interrupt lines and routes them to several processor contexts. Each line passes through its own gateway, which turns a level or a rising edge into a pending request. It then holds back further requests from that line while a context is servicing it. Every context has an enable bit per source and a priority threshold. It sees a single interrupt output that is high while at least one enabled, pending source of nonzero priority reaches that threshold.

Software services an interrupt by reading the context's claim register. The read returns the best source ID and atomically moves that source into service. Software later writes the same ID back to the same register to complete it. All configuration and the claim/complete handshake use one single-cycle register port. Read data is combinational from the address, and side effects take place at the clock edge that ends the access.

Each gateway is a three-state machine: GW_IDLE, GW_PEND and GW_SERV. It has four transitions:
- arrive: GW_IDLE to GW_PEND when the line requests.
- replay: GW_IDLE to GW_PEND when the line is in edge mode and has a stored edge, consuming one stored edge.
- claim: GW_PEND to GW_SERV when a context claims the source.
- complete: GW_SERV to GW_IDLE on a completion from the owning context.

A build option chooses whether edges seen in GW_SERV are stored for replay or dropped.

Top module: `plic_core`

## Requirements
- R1: After reset every pending bit, priority, enable mask, threshold and trigger-mode bit is zero, and every interrupt output is low.
- R2: Context c has an enable mask at address 0x40+4c, where bit s enables source s. Bit 0 reads zero. A source raises and can be claimed only by the contexts whose bit for it is set.
- R3: Among eligible sources the claim returns the highest priority. Priorities are written at address s for source s (1..NSRC), with PW bits. Among equal priorities the lowest source ID wins.
- R4: Context c has a threshold at address 0x41+4c. A source with priority below the threshold, or with priority 0, neither raises the output nor is returned by a claim, though its pending bit is still set.
- R5: A read of the claim register at address 0x42+4c returns the chosen ID, or 0 when nothing is eligible. A nonzero claim clears the source's pending bit at that edge, and the source stays not pending until it is completed, even if its line stays asserted.
- R6: Writing an ID to address 0x42+4c completes that source only if it is in service and was claimed by context c. Any other completion leaves every pending bit unchanged.
- R7: In level mode a pending bit stays set until claimed, even if the line drops. After completion it is set again one cycle later if the line is still high.
- R8: The trigger-mode register at address 0x80 selects edge mode for source s when bit s is 1. In edge mode only a 0-to-1 change sets pending, and a line held high does not set pending again after completion.
- R9: With edge queueing built in, rising edges seen during service are counted up to QMAX, saturating. After completion each stored edge yields one new pending request.
- R10: With edge queueing not built in, rising edges during service are dropped, and no pending request follows completion.
- R11: A context whose CTX_PRESENT bit is 0 keeps its output low, ignores writes, and reads zero from its enable, threshold and claim registers.
- R12: The pending register at address 0xC0 shows bit s set for each source in GW_PEND.

Address bits [7:6] select the register kind: 0 is priority, 1 is context, 2 is mode and 3 is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | NSRC | Interrupt lines; bit s-1 is source ID s |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (a claim read has a side effect) |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, combinational from the address |
| irq_out | output | NCTX | Interrupt output per context |

## Verification
On every cycle, the assertions check three things. A claimed source was pending at the moment it was claimed, and it is no longer pending one cycle later. No context output is high without some pending source. No stored-edge counter passes its ceiling. Only the bench scenarios can show the choices that depend on configuration history. These are the priority and lowest-ID ordering, threshold masking, and ignored completions from the wrong context or ID. They also cover level re-arming, the count of replays after a burst of edges in each build option, and the silence of an absent context.

// File: rtl/plic_pkg.sv
package plic_pkg;

    // Gateway state per source
    typedef enum logic [1:0] {
        GW_IDLE = 2'd0,
        GW_PEND = 2'd1,
        GW_SERV = 2'd2
    } gw_state_e;

    // Register kind, taken from the two top address bits
    typedef enum logic [1:0] {
        RK_PRIO = 2'd0,
        RK_CTX  = 2'd1,
        RK_MODE = 2'd2,
        RK_PEND = 2'd3
    } reg_kind_e;

    // Register select inside a context window
    localparam logic [1:0] SEL_EN    = 2'd0;
    localparam logic [1:0] SEL_THR   = 2'd1;
    localparam logic [1:0] SEL_CLAIM = 2'd2;

endpackage

// File: rtl/plic_gateway.sv
module plic_gateway
    import plic_pkg::*;
#(
    parameter int NCTX       = 2,
    parameter bit EDGE_QUEUE = 1'b1,
    parameter int QMAX       = 3,
    localparam int CTX_W     = (NCTX > 1) ? $clog2(NCTX) : 1,
    localparam int CNT_W     = $clog2(QMAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_in,
    input  logic             edge_mode,
    input  logic             claim,
    input  logic [CTX_W-1:0] claim_ctx,
    input  logic             cmpl,
    input  logic [CTX_W-1:0] cmpl_ctx,
    output logic             pend,
    output logic [CNT_W-1:0] qcnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(QMAX);

    gw_state_e        st_q, st_d;
    logic             src_q;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CTX_W-1:0] own_q, own_d;
    logic             rise;
    logic             req;
    logic             q_inc;

    assign rise = src_in & ~src_q;
    assign req  = edge_mode ? rise : src_in;

    // Variant: store edges seen in service, or drop them
    generate
        if (EDGE_QUEUE) begin : g_queue
            assign q_inc = edge_mode && (st_q == GW_SERV) && rise && (cnt_q != CNT_MAX);
        end else begin : g_drop
            assign q_inc = 1'b0;
        end
    endgenerate

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= GW_IDLE;
            src_q <= 1'b0;
            cnt_q <= '0;
            own_q <= '0;
        end else begin
            st_q  <= st_d;
            src_q <= src_in;
            cnt_q <= cnt_d;
            own_q <= own_d;
        end
    end

    // Next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        own_d = own_q;
        unique case (st_q)
            GW_IDLE: begin
                if (req) begin
                    st_d = GW_PEND;                 // arrive
                end else if (edge_mode && cnt_q != '0) begin
                    st_d  = GW_PEND;                // replay
                    cnt_d = cnt_q - 1'b1;
                end
            end
            GW_PEND: begin
                if (claim) begin
                    st_d  = GW_SERV;                // claim
                    own_d = claim_ctx;
                end
            end
            GW_SERV: begin
                if (cmpl && cmpl_ctx == own_q) begin
                    st_d = GW_IDLE;                 // complete
                end
            end
            default: st_d = GW_IDLE;
        endcase
        if (q_inc) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        pend = (st_q == GW_PEND);
        qcnt = cnt_q;
    end

endmodule

// File: rtl/plic_arbiter.sv
module plic_arbiter #(
    parameter int NSRC = 8,
    parameter int PW   = 3,
    localparam int ID_W = $clog2(NSRC + 1)
) (
    input  logic [NSRC:0]         pend,
    input  logic [NSRC:0]         en,
    input  logic [NSRC:0][PW-1:0] prio,
    input  logic [PW-1:0]         thr,
    output logic [ID_W-1:0]       best_id,
    output logic                  irq
);

    logic          found;
    logic [PW-1:0] best_p;

    // Scan downward with >= so that the lowest ID wins a tie
    always_comb begin
        found   = 1'b0;
        best_p  = '0;
        best_id = '0;
        for (int s = NSRC; s >= 1; s--) begin
            if (pend[s] && en[s] && prio[s] != '0 && prio[s] >= thr &&
                (!found || prio[s] >= best_p)) begin
                found   = 1'b1;
                best_p  = prio[s];
                best_id = ID_W'(s);
            end
        end
        irq = found;
    end

endmodule

// File: rtl/plic_core.sv
module plic_core
    import plic_pkg::*;
#(
    parameter int              NSRC        = 8,
    parameter int              NCTX        = 2,
    parameter int              PW          = 3,
    parameter logic [NCTX-1:0] CTX_PRESENT = '1,
    parameter bit              EDGE_QUEUE  = 1'b1,
    parameter int              QMAX        = 3,
    parameter int              AW          = 8,
    parameter int              DW          = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_irq,
    input  logic            reg_we,
    input  logic            reg_re,
    input  logic [AW-1:0]   reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic [NCTX-1:0] irq_out
);

    localparam int ID_W  = $clog2(NSRC + 1);
    localparam int CTX_W = (NCTX > 1) ? $clog2(NCTX) : 1;
    localparam int CNT_W = $clog2(QMAX + 1);
    localparam int IDX_W = AW - 2;
    localparam int NUM_W = AW - 4;

    // Address decode
    reg_kind_e        kind;
    logic [IDX_W-1:0] idx;
    logic [1:0]       sel;
    logic [NUM_W-1:0] ctx_num;
    logic             ctx_ok;
    logic [CTX_W-1:0] ctx_idx;

    assign kind    = reg_kind_e'(reg_addr[AW-1:AW-2]);
    assign idx     = reg_addr[IDX_W-1:0];
    assign sel     = reg_addr[1:0];
    assign ctx_num = reg_addr[IDX_W-1:2];

    // Configuration state
    logic [NSRC:0][PW-1:0] prio_q;
    logic [NSRC:0]         mode_q;
    logic [NCTX-1:0][NSRC:0] en_w;
    logic [NCTX-1:0][PW-1:0] thr_w;
    logic [NCTX-1:0]         we_en, we_thr;

    // Arbitration and gateway wiring
    logic [NCTX-1:0][ID_W-1:0] best_id;
    logic [NCTX-1:0]           ctx_irq;
    logic [NSRC-1:0]           gw_pend;
    logic [NSRC:0]             pend_vec;
    logic [NSRC-1:0][CNT_W-1:0] qcnt;
    logic [ID_W-1:0]           claim_id;
    logic                      claim_fire;
    logic                      cmpl_fire;

    assign pend_vec = {gw_pend, 1'b0};

    always_comb begin
        ctx_ok  = 1'b0;
        ctx_idx = '0;
        for (int c = 0; c < NCTX; c++) begin
            if (kind == RK_CTX && ctx_num == NUM_W'(c) && CTX_PRESENT[c]) begin
                ctx_ok  = 1'b1;
                ctx_idx = CTX_W'(c);
            end
        end
    end

    always_comb begin
        for (int c = 0; c < NCTX; c++) begin
            we_en[c]  = reg_we && ctx_ok && ctx_idx == CTX_W'(c) && sel == SEL_EN;
            we_thr[c] = reg_we && ctx_ok && ctx_idx == CTX_W'(c) && sel == SEL_THR;
        end
    end

    always_comb begin
        claim_id = '0;
        for (int c = 0; c < NCTX; c++) begin
            if (ctx_idx == CTX_W'(c)) begin
                claim_id = best_id[c];
            end
        end
    end

    assign claim_fire = reg_re && ctx_ok && sel == SEL_CLAIM && claim_id != '0;
    assign cmpl_fire  = reg_we && ctx_ok && sel == SEL_CLAIM;

    // Global registers: priorities and trigger modes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prio_q <= '0;
            mode_q <= '0;
        end else if (reg_we) begin
            if (kind == RK_PRIO) begin
                for (int s = 1; s <= NSRC; s++) begin
                    if (idx == IDX_W'(s)) begin
                        prio_q[s] <= reg_wdata[PW-1:0];
                    end
                end
            end
            if (kind == RK_MODE) begin
                mode_q <= {reg_wdata[NSRC:1], 1'b0};
            end
        end
    end

    // Per-context registers and arbiters; absent slots are tied off
    generate
        for (genvar c = 0; c < NCTX; c++) begin : g_ctx
            if (CTX_PRESENT[c]) begin : g_on
                logic [NSRC:0]  en_r;
                logic [PW-1:0]  thr_r;
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        en_r  <= '0;
                        thr_r <= '0;
                    end else begin
                        if (we_en[c])  en_r  <= {reg_wdata[NSRC:1], 1'b0};
                        if (we_thr[c]) thr_r <= reg_wdata[PW-1:0];
                    end
                end
                assign en_w[c]  = en_r;
                assign thr_w[c] = thr_r;
                plic_arbiter #(
                    .NSRC (NSRC),
                    .PW   (PW)
                ) u_arb (
                    .pend    (pend_vec),
                    .en      (en_r),
                    .prio    (prio_q),
                    .thr     (thr_r),
                    .best_id (best_id[c]),
                    .irq     (ctx_irq[c])
                );
            end else begin : g_off
                assign en_w[c]    = '0;
                assign thr_w[c]   = '0;
                assign best_id[c] = '0;
                assign ctx_irq[c] = 1'b0;
            end
        end
    endgenerate

    assign irq_out = ctx_irq;

    // Gateways, one per source
    generate
        for (genvar s = 1; s <= NSRC; s++) begin : g_src
            plic_gateway #(
                .NCTX       (NCTX),
                .EDGE_QUEUE (EDGE_QUEUE),
                .QMAX       (QMAX)
            ) u_gw (
                .clk       (clk),
                .rst_n     (rst_n),
                .src_in    (src_irq[s-1]),
                .edge_mode (mode_q[s]),
                .claim     (claim_fire && claim_id == ID_W'(s)),
                .claim_ctx (ctx_idx),
                .cmpl      (cmpl_fire && reg_wdata == DW'(s)),
                .cmpl_ctx  (ctx_idx),
                .pend      (gw_pend[s-1]),
                .qcnt      (qcnt[s-1])
            );
        end
    endgenerate

    // Read mux
    always_comb begin
        reg_rdata = '0;
        unique case (kind)
            RK_PRIO: begin
                for (int s = 1; s <= NSRC; s++) begin
                    if (idx == IDX_W'(s)) reg_rdata = DW'(prio_q[s]);
                end
            end
            RK_CTX: begin
                for (int c = 0; c < NCTX; c++) begin
                    if (ctx_ok && ctx_idx == CTX_W'(c)) begin
                        unique case (sel)
                            SEL_EN:    reg_rdata = DW'(en_w[c]);
                            SEL_THR:   reg_rdata = DW'(thr_w[c]);
                            SEL_CLAIM: reg_rdata = DW'(best_id[c]);
                            default:   reg_rdata = '0;
                        endcase
                    end
                end
            end
            RK_MODE: reg_rdata = DW'(mode_q);
            RK_PEND: reg_rdata = DW'(pend_vec);
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/plic_checker.sv
module plic_checker #(
    parameter int NSRC  = 8,
    parameter int NCTX  = 2,
    parameter int QMAX  = 3,
    parameter int CNT_W = 2,
    parameter int ID_W  = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NCTX-1:0]            irq_out,
    input logic [NSRC:0]              pend_vec,
    input logic                       claim_fire,
    input logic [ID_W-1:0]            claim_id,
    input logic [NSRC-1:0][CNT_W-1:0] qcnt
);

    // R5: the arbiter only hands out a source the gateway holds pending
    p_claim_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        claim_fire |-> pend_vec[claim_id]);

    // R5: the claim leaves the source not pending
    p_claim_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        claim_fire |=> !pend_vec[$past(claim_id)]);

    // R4: an output needs at least one pending source behind it
    p_irq_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_out) |-> (|pend_vec));

    // R9: stored-edge counters saturate
    generate
        for (genvar s = 0; s < NSRC; s++) begin : g_cnt
            p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
                qcnt[s] <= CNT_W'(QMAX));
        end
    endgenerate

endmodule

bind plic_core plic_checker #(
    .NSRC  (NSRC),
    .NCTX  (NCTX),
    .QMAX  (QMAX),
    .CNT_W (CNT_W),
    .ID_W  (ID_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_out    (irq_out),
    .pend_vec   (pend_vec),
    .claim_fire (claim_fire),
    .claim_id   (claim_id),
    .qcnt       (qcnt)
);

// File: tb/tb_plic_core.sv
`timescale 1ns/1ps
module tb_plic_core;

    localparam int NSRC = 8;
    localparam int NCTX = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src = '0;
    logic            we = 1'b0;
    logic            re = 1'b0;
    logic [7:0]      addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata, rdata2;
    logic [NCTX-1:0] irq, irq2;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [31:0] exp_q[$];
    logic [31:0] act_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    plic_core #(.NSRC(NSRC), .NCTX(NCTX), .PW(3), .CTX_PRESENT(3'b011),
                .EDGE_QUEUE(1'b1), .QMAX(2)) dut (
        .clk(clk), .rst_n(rst_n), .src_irq(src), .reg_we(we), .reg_re(re),
        .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq_out(irq));

    plic_core #(.NSRC(NSRC), .NCTX(NCTX), .PW(3), .CTX_PRESENT(3'b011),
                .EDGE_QUEUE(1'b0), .QMAX(2)) dut_drop (
        .clk(clk), .rst_n(rst_n), .src_irq(src), .reg_we(we), .reg_re(re),
        .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata2), .irq_out(irq2));

    // Driver side: push expected item and observed sample
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tag_q.push_back(tag);
        act_q.push_back(act);
        exp_q.push_back(exp);
    endtask

    // Monitor: pop and compare
    initial begin
        forever begin
            @(posedge clk);
            while (exp_q.size() > 0) begin
                logic [31:0] e;
                logic [31:0] a;
                string t;
                e = exp_q.pop_front();
                a = act_q.pop_front();
                t = tag_q.pop_front();
                n_cmp++;
                if (a !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", t, a, e);
                end
            end
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v, output logic [31:0] v2);
        @(negedge clk);
        addr = a; re = 1'b1;
        #1;
        v  = rdata;
        v2 = rdata2;
        @(negedge clk);
        re = 1'b0;
    endtask

    task automatic pulse(input int s);
        @(negedge clk);
        src[s-1] = 1'b1;
        @(negedge clk);
        src[s-1] = 1'b0;
    endtask

    function automatic logic [7:0] a_en(input int c);  return 8'(8'h40 + 4*c); endfunction
    function automatic logic [7:0] a_thr(input int c); return 8'(8'h41 + 4*c); endfunction
    function automatic logic [7:0] a_clm(input int c); return 8'(8'h42 + 4*c); endfunction
    localparam logic [7:0] A_MODE = 8'h80;
    localparam logic [7:0] A_PEND = 8'hC0;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        step();

        // R1: reset state
        chk("R1 irq after reset", 32'(irq), 32'h0);
        rd(A_PEND, v, v2);  chk("R1 pending after reset", v, 32'h0);
        rd(8'h03, v, v2);   chk("R1 priority after reset", v, 32'h0);
        rd(a_clm(0), v, v2); chk("R5 claim with nothing eligible", v, 32'h0);

        // configuration
        wr(8'h01, 1); wr(8'h02, 5); wr(8'h03, 5);
        wr(8'h05, 3); wr(8'h06, 2); wr(8'h07, 4);
        wr(a_en(0), 32'h7E); wr(a_en(1), 32'h04);
        rd(a_en(1), v, v2); chk("R2 enable readback", v, 32'h04);

        // R11: absent context
        wr(a_en(2), 32'hFE); wr(a_thr(2), 1);
        rd(a_en(2), v, v2);  chk("R11 absent enable", v, 32'h0);
        rd(a_thr(2), v, v2); chk("R11 absent threshold", v, 32'h0);

        // R2: per-context enable
        src[5] = 1'b1;
        step(); step();
        chk("R2 ctx0 raised", 32'(irq[0]), 32'h1);
        chk("R2 ctx1 not enabled", 32'(irq[1]), 32'h0);
        chk("R11 absent output low", 32'(irq[2]), 32'h0);
        rd(a_clm(2), v, v2); chk("R11 absent claim", v, 32'h0);

        // R3: priority and tie order
        src[1] = 1'b1; src[2] = 1'b1;
        step(); step();
        rd(A_PEND, v, v2);   chk("R12 pending bits", v, 32'h4C);
        rd(a_clm(0), v, v2); chk("R3 tie lowest ID", v, 32'd2);
        rd(A_PEND, v, v2);   chk("R5 claim clears pending", v, 32'h48);
        rd(a_clm(0), v, v2); chk("R3 second of tie", v, 32'd3);
        rd(a_clm(0), v, v2); chk("R3 lower priority last", v, 32'd6);
        rd(a_clm(0), v, v2); chk("R5 no re-request in service", v, 32'd0);

        // R6: ignored completions
        wr(a_clm(1), 2);
        rd(A_PEND, v, v2); chk("R6 wrong context ignored", v, 32'h0);
        wr(a_clm(0), 4);
        rd(A_PEND, v, v2); chk("R6 unclaimed ID ignored", v, 32'h0);

        // R7: level re-arm
        wr(a_clm(0), 2);
        rd(A_PEND, v, v2); chk("R7 re-pend while high", v, 32'h04);
        src = '0;
        step();
        rd(A_PEND, v, v2); chk("R7 pending held after drop", v, 32'h04);
        rd(a_clm(1), v, v2); chk("R2 ctx1 claims enabled source", v, 32'd2);
        wr(a_clm(1), 2); wr(a_clm(0), 3); wr(a_clm(0), 6);
        rd(A_PEND, v, v2); chk("R7 no re-pend when low", v, 32'h0);

        // R4: threshold
        wr(a_thr(0), 4);
        src[4] = 1'b1; src[0] = 1'b1;
        step(); step();
        chk("R4 below threshold no irq", 32'(irq[0]), 32'h0);
        rd(a_clm(0), v, v2); chk("R4 below threshold no claim", v, 32'd0);
        wr(a_thr(0), 3);
        chk("R4 at threshold irq", 32'(irq[0]), 32'h1);
        rd(a_clm(0), v, v2); chk("R4 at threshold claim", v, 32'd5);
        wr(a_thr(0), 0);
        rd(a_clm(0), v, v2); chk("R4 threshold lowered", v, 32'd1);
        src = '0;
        wr(a_clm(0), 5); wr(a_clm(0), 1);
        rd(A_PEND, v, v2); chk("R4 all completed", v, 32'h0);

        // R8: edge mode
        wr(a_en(0), 32'hFE);
        wr(A_MODE, 32'h80);
        rd(A_MODE, v, v2); chk("R8 mode readback", v, 32'h80);
        src[6] = 1'b1;
        step(); step();
        rd(A_PEND, v, v2);   chk("R8 edge sets pending", v, 32'h80);
        rd(a_clm(0), v, v2); chk("R8 edge claim", v, 32'd7);
        wr(a_clm(0), 7);
        step(); step();
        rd(A_PEND, v, v2);   chk("R8 held line no re-pend", v, 32'h0);
        chk("R10 held line no re-pend", v2, 32'h0);
        src[6] = 1'b0;
        step();

        // R9 / R10: edges during service
        pulse(7);
        step();
        rd(A_PEND, v, v2);   chk("R8 pulse pending", v, 32'h80);
        chk("R10 pulse pending", v2, 32'h80);
        rd(a_clm(0), v, v2); chk("R9 claim pulse", v, 32'd7);
        chk("R10 claim pulse", v2, 32'd7);
        pulse(7); pulse(7); pulse(7);
        wr(a_clm(0), 7);
        rd(A_PEND, v, v2);   chk("R9 first replay", v, 32'h80);
        chk("R10 edges dropped", v2, 32'h0);
        rd(a_clm(0), v, v2); chk("R9 claim replay", v, 32'd7);
        chk("R10 nothing to claim", v2, 32'd0);
        wr(a_clm(0), 7);
        rd(A_PEND, v, v2);   chk("R9 second replay", v, 32'h80);
        rd(a_clm(0), v, v2); chk("R9 claim second replay", v, 32'd7);
        wr(a_clm(0), 7);
        rd(A_PEND, v, v2);   chk("R9 saturated at two", v, 32'h0);
        chk("R10 still idle", v2, 32'h0);

        // R4: priority zero never interrupts
        src[3] = 1'b1;
        step(); step();
        rd(A_PEND, v, v2);   chk("R4 prio0 pending", v, 32'h10);
        chk("R4 prio0 no irq", 32'(irq[0]), 32'h0);
        rd(a_clm(0), v, v2); chk("R4 prio0 no claim", v, 32'd0);

        repeat (3) @(posedge clk);
        #1;
        if (!done) begin
            done = 1'b1;
            summary();
            $finish;
        end
    end

endmodule